// File: doc/BRIEF.md
# Card Socket Power-Up Sequencer

This block walks a removable card socket through a safe power cycle. An enable request first forces both supply controls to their off codes and holds them off long enough for any earlier supply to collapse. It then switches the card supply to its 5 V code and waits for it to rise and settle. Next it pulses the card reset line for a fixed minimum width. A last settle period follows, and then the socket is reported ready. A disable request turns both supplies off and waits out the fall time before the block returns to idle.

All waits are counted in microsecond ticks. A prescaler makes these ticks from the clock, and a parameter gives the number of clock cycles per microsecond. Each wait length is a parameter in microseconds, so a test setup can shrink the sequence without changing the logic. A card-removal event overrides everything else and sends the block straight into the power-down sequence. Requests that arrive while a sequence is running are dropped.

Top module: `socket_pwr_seq`

## Requirements
- R1: After reset the block is idle: vcc_ctl = 2'b00, vpp_ctl = 2'b00, card_rst = 0, busy = 0, ready = 0.
- R2: Supply codes are 2-bit fields. For vcc_ctl, 2'b00 means 0 V and 2'b01 means 5 V. vpp_ctl is always 2'b00 (0 V). Both fields are updated on the same clock edge.
- R3: Every wait phase of N microseconds lasts exactly N*TICKS_PER_US clock cycles, because the prescaler restarts at the start of each phase.
- R4: The cycle after an accepted enable request, busy = 1 and vcc_ctl = 2'b00. Power stays off for (OFF_US + FALL_US) microseconds.
- R5: vcc_ctl then goes to 2'b01, with card_rst low, for RISE_US microseconds.
- R6: card_rst is then high for RESET_US microseconds, with vcc_ctl held at 2'b01, and then goes low.
- R7: After a further SETTLE_US microseconds, ready rises and busy falls on the same edge. ready and busy are never high together.
- R8: A disable request accepted while not busy drives vcc_ctl = 2'b00 and holds busy for DOWN_US microseconds. After that the block is idle with ready = 0.
- R9: card_gone, in any state, starts the disable sequence on the next edge: vcc_ctl = 2'b00, card_rst = 0, busy = 1, ready = 0. A full DOWN_US wait follows. card_gone takes priority over both requests.
- R10: en_req and dis_req have no effect while busy = 1; the running sequence keeps its length.
- R11: A request is accepted when busy = 0, whether the block is idle or ready. If en_req and dis_req arrive together, disable wins. An en_req while ready restarts the full enable sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_req | input | 1 | Request a power-up sequence |
| dis_req | input | 1 | Request a power-down sequence |
| card_gone | input | 1 | Card removal event; forces power-down |
| vcc_ctl | output | 2 | Card supply code (00 = 0 V, 01 = 5 V) |
| vpp_ctl | output | 2 | Programming supply code (00 = 0 V) |
| card_rst | output | 1 | Card reset line, active high |
| busy | output | 1 | A sequence is in progress |
| ready | output | 1 | The socket is powered and out of reset |

## Verification
A wrong phase register shows up at the ports on the next cycle: a wrong supply code, a reset pulse at the wrong time, or busy and ready in the wrong state. An off-by-one in the prescaler or the microsecond counter does not change any level. It only moves the phase boundaries, so the bench counts how many cycles each phase lasts and compares every output against a reference model on every clock. A card-removal or dropped-request bug shows up within one cycle as a missing power-down, or later as a sequence of the wrong total length.

// File: rtl/sps_pkg.sv
package sps_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_DROP   = 3'd1,
        PH_FALL   = 3'd2,
        PH_RISE   = 3'd3,
        PH_RESET  = 3'd4,
        PH_SETTLE = 3'd5,
        PH_ON     = 3'd6,
        PH_DOWN   = 3'd7
    } phase_e;

    localparam logic [1:0] VCC_OFF = 2'b00;
    localparam logic [1:0] VCC_5V  = 2'b01;
    localparam logic [1:0] VPP_OFF = 2'b00;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned bits_for(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/sps_us_tick.sv
module sps_us_tick #(
    parameter int unsigned TICKS_PER_US = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int unsigned PW = sps_pkg::bits_for(TICKS_PER_US);
    localparam logic [PW-1:0] LAST = PW'(TICKS_PER_US - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == LAST);

    always_comb begin
        if (clear || tick) cnt_d = '0;
        else               cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sps_span_timer.sv
module sps_span_timer #(
    parameter int unsigned US_W = 19
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            tick,
    input  logic [US_W-1:0] len_us,
    output logic            done
);
    logic [US_W-1:0] us_d, us_q;

    assign done = tick && (us_q == len_us - 1'b1);

    always_comb begin
        if (clear)     us_d = '0;
        else if (tick) us_d = us_q + 1'b1;
        else           us_d = us_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) us_q <= '0;
        else        us_q <= us_d;
    end
endmodule

// File: rtl/socket_pwr_seq.sv
module socket_pwr_seq #(
    parameter int unsigned TICKS_PER_US = 125,
    parameter int unsigned OFF_US       = 20000,
    parameter int unsigned FALL_US      = 400000,
    parameter int unsigned RISE_US      = 420000,
    parameter int unsigned RESET_US     = 10,
    parameter int unsigned SETTLE_US    = 20000,
    parameter int unsigned DOWN_US      = 320000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_req,
    input  logic       dis_req,
    input  logic       card_gone,
    output logic [1:0] vcc_ctl,
    output logic [1:0] vpp_ctl,
    output logic       card_rst,
    output logic       busy,
    output logic       ready
);
    import sps_pkg::*;

    localparam int unsigned MAX_US = umax(umax(umax(OFF_US, FALL_US), umax(RISE_US, RESET_US)),
                                          umax(SETTLE_US, DOWN_US));
    localparam int unsigned US_W = bits_for(MAX_US);

    typedef struct packed {
        phase_e     ph;
        logic [1:0] vcc;
        logic [1:0] vpp;
        logic       crst;
        logic       busy;
        logic       ready;
    } seq_t;

    seq_t            s_d, s_q;
    logic            load;
    logic            tick;
    logic            done;
    logic [US_W-1:0] len_us;
    phase_e          nxt;

    sps_us_tick #(.TICKS_PER_US(TICKS_PER_US)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load),
        .tick  (tick)
    );

    sps_span_timer #(.US_W(US_W)) u_span (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (load),
        .tick   (tick),
        .len_us (len_us),
        .done   (done)
    );

    // wait length of the phase currently held
    always_comb begin
        unique case (s_q.ph)
            PH_DROP:   len_us = US_W'(OFF_US);
            PH_FALL:   len_us = US_W'(FALL_US);
            PH_RISE:   len_us = US_W'(RISE_US);
            PH_RESET:  len_us = US_W'(RESET_US);
            PH_SETTLE: len_us = US_W'(SETTLE_US);
            PH_DOWN:   len_us = US_W'(DOWN_US);
            default:   len_us = US_W'(1);
        endcase
    end

    always_comb begin
        nxt  = s_q.ph;
        load = 1'b0;
        if (card_gone) begin
            nxt  = PH_DOWN;
            load = 1'b1;
        end else begin
            unique case (s_q.ph)
                PH_IDLE, PH_ON: begin
                    if (dis_req) begin
                        nxt  = PH_DOWN;
                        load = 1'b1;
                    end else if (en_req) begin
                        nxt  = PH_DROP;
                        load = 1'b1;
                    end
                end
                PH_DROP:   if (done) begin nxt = PH_FALL;   load = 1'b1; end
                PH_FALL:   if (done) begin nxt = PH_RISE;   load = 1'b1; end
                PH_RISE:   if (done) begin nxt = PH_RESET;  load = 1'b1; end
                PH_RESET:  if (done) begin nxt = PH_SETTLE; load = 1'b1; end
                PH_SETTLE: if (done) begin nxt = PH_ON;     load = 1'b1; end
                PH_DOWN:   if (done) begin nxt = PH_IDLE;   load = 1'b1; end
                default:   begin nxt = PH_IDLE; load = 1'b1; end
            endcase
        end

        s_d.ph    = nxt;
        s_d.vpp   = VPP_OFF;
        s_d.vcc   = (nxt == PH_RISE || nxt == PH_RESET ||
                     nxt == PH_SETTLE || nxt == PH_ON) ? VCC_5V : VCC_OFF;
        s_d.crst  = (nxt == PH_RESET);
        s_d.ready = (nxt == PH_ON);
        s_d.busy  = (nxt != PH_ON) && (nxt != PH_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ph    <= PH_IDLE;
            s_q.vcc   <= VCC_OFF;
            s_q.vpp   <= VPP_OFF;
            s_q.crst  <= 1'b0;
            s_q.busy  <= 1'b0;
            s_q.ready <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign vcc_ctl  = s_q.vcc;
    assign vpp_ctl  = s_q.vpp;
    assign card_rst = s_q.crst;
    assign busy     = s_q.busy;
    assign ready    = s_q.ready;
endmodule

// File: rtl/sps_checker.sv
module sps_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       en_req,
    input logic       dis_req,
    input logic       card_gone,
    input logic [1:0] vcc_ctl,
    input logic [1:0] vpp_ctl,
    input logic       card_rst,
    input logic       busy,
    input logic       ready
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ready) |-> (vcc_ctl == 2'b00 && !card_rst));

    assert_vpp_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_ctl == 2'b00);

    assert_rst_powered_R6: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |-> (vcc_ctl == 2'b01 && busy));

    assert_ready_handoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $fell(busy));

    assert_not_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && ready));

    assert_gone_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
        card_gone |=> (busy && !ready && vcc_ctl == 2'b00 && !card_rst));

    assert_dis_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && dis_req && en_req && !card_gone) |=> (busy && vcc_ctl == 2'b00 && !ready));

    assert_en_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && en_req && !card_gone) |=> (busy && vcc_ctl == 2'b00));
endmodule

bind socket_pwr_seq sps_checker u_chk (.*);

// File: tb/sim_socket_pwr_seq.sv
`timescale 1ns/1ps
module sim_socket_pwr_seq;
    localparam int TPU = 3, T_OFF = 4, T_FALL = 5, T_RISE = 6, T_RST = 2, T_SET = 3, T_DN = 7;
    localparam int C_OFF = (T_OFF + T_FALL) * TPU;
    localparam int C_ON  = T_RISE * TPU;
    localparam int C_RST = T_RST * TPU;
    localparam int C_SET = T_SET * TPU;
    localparam int C_EN  = C_OFF + C_ON + C_RST + C_SET;
    localparam int C_DN  = T_DN * TPU;

    logic clk = 0, rst_n = 0, en_req = 0, dis_req = 0, card_gone = 0;
    logic [1:0] vcc_ctl, vpp_ctl;
    logic card_rst, busy, ready;
    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    socket_pwr_seq #(.TICKS_PER_US(TPU), .OFF_US(T_OFF), .FALL_US(T_FALL), .RISE_US(T_RISE),
                     .RESET_US(T_RST), .SETTLE_US(T_SET), .DOWN_US(T_DN)) u0 (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req), .card_gone(card_gone),
        .vcc_ctl(vcc_ctl), .vpp_ctl(vpp_ctl), .card_rst(card_rst), .busy(busy), .ready(ready));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: mode 0 idle, 1 off, 2 vcc up, 3 reset, 4 settle, 5 on, 6 down
    int m_mode = 0, m_left = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_left = 0;
        end else if (card_gone) begin
            m_mode = 6; m_left = C_DN;
        end else if (m_mode == 0 || m_mode == 5) begin
            if (dis_req)     begin m_mode = 6; m_left = C_DN;  end
            else if (en_req) begin m_mode = 1; m_left = C_OFF; end
        end else if (m_left > 1) begin
            m_left--;
        end else begin
            case (m_mode)
                1: begin m_mode = 2; m_left = C_ON;  end
                2: begin m_mode = 3; m_left = C_RST; end
                3: begin m_mode = 4; m_left = C_SET; end
                4: begin m_mode = 5; m_left = 0;     end
                default: begin m_mode = 0; m_left = 0; end
            endcase
        end
    end

    function automatic string tag_of(input int md);
        case (md)
            0: return "R1";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R7";
            default: return "R8";
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int ev, eb, er, ey;
            ev = (m_mode >= 2 && m_mode <= 5) ? 1 : 0;
            eb = (m_mode >= 1 && m_mode <= 4) || m_mode == 6;
            er = (m_mode == 3);
            ey = (m_mode == 5);
            chk(vcc_ctl == 2'(ev), {tag_of(m_mode), " vcc"}, vcc_ctl, ev);
            chk(vpp_ctl == 2'b00, "R2 vpp", vpp_ctl, 0);
            chk(card_rst == 1'(er), {tag_of(m_mode), " card_rst"}, card_rst, er);
            chk(busy == 1'(eb), {tag_of(m_mode), " busy"}, busy, eb);
            chk(ready == 1'(ey), {tag_of(m_mode), " ready"}, ready, ey);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic issue(input bit e, input bit d, input bit g);
        @(negedge clk);
        en_req = e; dis_req = d; card_gone = g;
        @(negedge clk);
        en_req = 0; dis_req = 0; card_gone = 0;
    endtask

    task automatic run_busy(input int inj_at, input int gone_at,
                            output int n_off, output int n_pre, output int n_rst,
                            output int n_post, output int total);
        bit seen_rst = 0;
        n_off = 0; n_pre = 0; n_rst = 0; n_post = 0; total = 0;
        while (busy) begin
            total++;
            if (card_rst) begin n_rst++; seen_rst = 1; end
            else if (vcc_ctl == 2'b00) n_off++;
            else if (!seen_rst) n_pre++;
            else n_post++;
            en_req = (total == inj_at); dis_req = (total == inj_at);
            card_gone = (total == gone_at);
            @(negedge clk);
        end
        en_req = 0; dis_req = 0; card_gone = 0;
    endtask

    initial begin
        int a, b, c, d, t;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(vcc_ctl == 2'b00 && vpp_ctl == 2'b00, "R1 supplies after reset", vcc_ctl, 0);
        chk(!card_rst && !busy && !ready, "R1 flags after reset", {card_rst, busy, ready}, 0);

        issue(1, 0, 0);
        chk(busy && vcc_ctl == 2'b00, "R4 first cycle of enable", {busy, vcc_ctl}, 4);
        run_busy(-1, -1, a, b, c, d, t);
        chk(a == C_OFF, "R4 off duration", a, C_OFF);
        chk(b == C_ON, "R5 vcc-before-reset duration", b, C_ON);
        chk(c == C_RST, "R6 reset width", c, C_RST);
        chk(d == C_SET, "R7 settle duration", d, C_SET);
        chk(t == C_EN, "R3 total enable cycles", t, C_EN);
        chk(ready && vcc_ctl == 2'b01, "R7 ready after enable", {ready, vcc_ctl}, 5);

        issue(1, 0, 0);
        chk(!ready && vcc_ctl == 2'b00, "R11 enable from ready restarts", {ready, vcc_ctl}, 0);
        run_busy(10, -1, a, b, c, d, t);
        chk(t == C_EN, "R10 requests while busy ignored", t, C_EN);
        chk(c == C_RST, "R10 reset width unchanged", c, C_RST);

        issue(0, 1, 0);
        run_busy(-1, -1, a, b, c, d, t);
        chk(t == C_DN && a == C_DN, "R8 disable duration", t, C_DN);
        chk(!ready && !busy && vcc_ctl == 2'b00, "R8 idle after disable", {ready, busy, vcc_ctl}, 0);

        issue(1, 1, 0);
        run_busy(-1, -1, a, b, c, d, t);
        chk(t == C_DN && b == 0 && d == 0, "R11 disable wins over enable", t, C_DN);

        issue(0, 0, 1);
        run_busy(-1, -1, a, b, c, d, t);
        chk(t == C_DN, "R9 removal while idle", t, C_DN);

        issue(1, 0, 0);
        run_busy(-1, 30, a, b, c, d, t);
        chk(t == 30 + C_DN, "R9 removal mid-sequence total", t, 30 + C_DN);
        chk(c == 0 && b == 3, "R9 no reset pulse after removal", c, 0);

        issue(1, 0, 0);
        run_busy(-1, -1, a, b, c, d, t);
        issue(1, 0, 1);
        chk(busy && !ready && vcc_ctl == 2'b00 && !card_rst, "R9 removal beats enable in ready",
            {busy, ready, vcc_ctl}, 8);
        run_busy(-1, -1, a, b, c, d, t);
        chk(t == C_DN, "R9 full down wait", t, C_DN);
        chk(vpp_ctl == 2'b00, "R2 vpp at end", vpp_ctl, 0);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule